// File: doc/BRIEF.md
# Detector UDP Packet Ingress Parser

This block sits behind an Ethernet receive MAC and screens incoming frames for detector data packets. Frames arrive as 512-bit stream beats. The parser checks the Ethernet, IPv4 and UDP headers of each frame against the locally configured MAC address, IPv4 address and UDP port. A frame that does not match is discarded. For a matching frame the parser decodes the little-endian detector header that follows the UDP header. It then emits one metadata record carrying the frame number, module number, packet position within the module, trigger flag and end-of-collection marker.

The 8192-byte pixel payload starts at byte 90 of the frame, which is not on a beat boundary. The parser shifts it into alignment and forwards it as 128 whole 64-byte beats. The metadata record is always handed over before the first payload beat of the same packet. A valid packet is exactly 130 beats long.

Payload is forwarded cut-through. A length fault that is found after forwarding has begun therefore closes the outgoing packet early, with an error marker on its final beat. The parser counts good packets and length faults in two counters that can be cleared.

Top module: `det_rx_parser`

## Requirements
- R1: A frame is processed only if all of the following hold on its first beat: destination MAC (bytes 0..5, big-endian) equals `local_mac`; bytes 12..13 are 0x0800; byte 14 is 0x45; bytes 16..17 are 8268; byte 23 is 0x11; bytes 30..33 equal `local_ip`; bytes 36..37 equal `udp_port`; bytes 38..39 are 8248; `in_user` is zero. Byte i of a frame sits at `in_data[8*(i%64)+:8]` of beat i/64. Any other frame is discarded through its last beat with no metadata, no payload and no counter change.
- R2: The detector fields are little-endian: frame number in bytes 42..49, packet number in bytes 50..53 (its low 6 bits used), coordinate in bytes 74..75, debug word in bytes 86..89.
- R3: The metadata record is formed as follows: `meta_module` is coordinate[5:1], `meta_packet` is {coordinate[0], packet number[5:0]}, `meta_trigger` is bit 31 of the debug word, and `meta_end` is 1 exactly when the frame number is all ones.
- R4: One metadata record is offered per processed frame of at least 3 beats, after its second beat is taken. It stays valid and stable until `meta_ready`. No input beat is taken while it is pending, and it is handed over before that frame's first payload beat.
- R5: For a good frame, 128 payload beats are sent; beat k carries frame bytes 90+64k to 153+64k in lane order. `out_last` is 1 only on beat 127, and `out_err` is 0.
- R6: A processed frame whose beat count is not 130, or that has a beat with `in_keep` not all ones, adds 1 to `len_err_count`. If payload was already being forwarded, the beat that ends forwarding has `out_last`=1 and `out_err`=1, and the remaining input beats are discarded. A frame of 1 or 2 beats gives no metadata and no payload.
- R7: `pkt_count` rises by exactly 1 for each good 130-beat frame. `clear_counters` zeroes both counters on the next cycle, taking priority over any increment.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_err` hold their values.
- R9: After reset, `meta_valid` and `out_valid` are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 512 | Input beat, byte i in bits 8i+7:8i |
| in_keep | input | 64 | Byte enables, all ones expected |
| in_last | input | 1 | Last beat of frame |
| in_user | input | 1 | MAC error flag, nonzero drops the frame |
| local_mac | input | 48 | Local MAC address |
| local_ip | input | 32 | Local IPv4 address |
| udp_port | input | 16 | Accepted UDP destination port |
| clear_counters | input | 1 | Synchronous clear of both counters |
| meta_valid | output | 1 | Metadata record valid |
| meta_ready | input | 1 | Metadata record taken |
| meta_frame | output | 64 | Frame number |
| meta_module | output | 5 | Module number |
| meta_packet | output | 7 | Packet index within module |
| meta_trigger | output | 1 | Trigger flag |
| meta_end | output | 1 | End-of-collection marker |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Payload beat taken |
| out_data | output | 512 | Aligned payload beat |
| out_last | output | 1 | Final payload beat of the packet |
| out_err | output | 1 | Packet closed early by a length fault |
| pkt_count | output | 32 | Good packet count |
| len_err_count | output | 32 | Length fault count |

## Verification
Several properties are checked on every cycle. Both output handshakes hold their values under back-pressure. A pending metadata record blocks input. Error-marked beats always close a packet. The counters advance by at most one per cycle and go to zero after a clear. Only the bench scenarios can show the rest: that each header field actually gates acceptance, that the little-endian fields land in the right record fields, that the 26-byte realignment picks the right bytes, and how the short, long and bad-keep frames close their payload.

// File: rtl/det_rx_pkg.sv
package det_rx_pkg;
   localparam int OFS_ETYPE   = 12;
   localparam int OFS_VERIHL  = 14;
   localparam int OFS_IPLEN   = 16;
   localparam int OFS_PROTO   = 23;
   localparam int OFS_DSTIP   = 30;
   localparam int OFS_DPORT   = 36;
   localparam int OFS_UDPLEN  = 38;
   localparam int OFS_FRAME   = 42;
   localparam int OFS_PKTNUM  = 50;
   localparam int OFS_COORD   = 74;
   localparam int OFS_DEBUG   = 86;
   localparam int OFS_PAYLOAD = 90;

   localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
   localparam logic [7:0]  VER_IHL_STD = 8'h45;
   localparam logic [15:0] IP_TOT_LEN  = 16'd8268;
   localparam logic [7:0]  PROTO_UDP   = 8'h11;
   localparam logic [15:0] UDP_TOT_LEN = 16'd8248;

   typedef struct packed {
      logic [47:0] dst_mac;
      logic [15:0] etype;
      logic [7:0]  ver_ihl;
      logic [15:0] ip_len;
      logic [7:0]  proto;
      logic [31:0] dst_ip;
      logic [15:0] dport;
      logic [15:0] udp_len;
   } net_hdr_t;

   typedef enum logic [2:0] {
      ST_HDR0, ST_HDR1, ST_META, ST_BODY, ST_DROP
   } rx_state_e;
endpackage

// File: rtl/det_rx_hdr_check.sv
module det_rx_hdr_check
   import det_rx_pkg::*;
#(
   parameter int  USER_W    = 1,
   parameter bit  CHECK_MAC = 1'b1
)(
   input  net_hdr_t            hdr,
   input  logic [USER_W-1:0]   user,
   input  logic [47:0]         local_mac,
   input  logic [31:0]         local_ip,
   input  logic [15:0]         udp_port,
   output logic                hdr_ok
);
   logic mac_ok;

   generate
      if (CHECK_MAC) begin : g_mac
         assign mac_ok = (hdr.dst_mac == local_mac);
      end else begin : g_nomac
         logic unused_mac;
         assign unused_mac = ^{hdr.dst_mac, local_mac};
         assign mac_ok = 1'b1;
      end
   endgenerate

   assign hdr_ok = mac_ok
                && (hdr.etype   == ETYPE_IPV4)
                && (hdr.ver_ihl == VER_IHL_STD)
                && (hdr.ip_len  == IP_TOT_LEN)
                && (hdr.proto   == PROTO_UDP)
                && (hdr.dst_ip  == local_ip)
                && (hdr.dport   == udp_port)
                && (hdr.udp_len == UDP_TOT_LEN)
                && (user == '0);
endmodule

// File: rtl/det_rx_realign.sv
module det_rx_realign #(
   parameter int DATA_W   = 512,
   parameter int HI_BYTES = 38,
   localparam int LO_BYTES = DATA_W/8 - HI_BYTES
)(
   input  logic [8*HI_BYTES-1:0] prev_hi,
   input  logic [8*LO_BYTES-1:0] cur_lo,
   output logic [DATA_W-1:0]     merged
);
   generate
      for (genvar b = 0; b < HI_BYTES; b++) begin : g_hi
         assign merged[8*b +: 8] = prev_hi[8*b +: 8];
      end
      for (genvar b = 0; b < LO_BYTES; b++) begin : g_lo
         assign merged[8*(HI_BYTES+b) +: 8] = cur_lo[8*b +: 8];
      end
   endgenerate
endmodule

// File: rtl/det_rx_counters.sv
module det_rx_counters #(
   parameter int N_CNT = 2,
   parameter int CNT_W = 32
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic [N_CNT-1:0]            inc,
   output logic [N_CNT-1:0][CNT_W-1:0] cnt
);
   generate
      for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt[i] <= '0;
            else if (clear)  cnt[i] <= '0;
            else if (inc[i]) cnt[i] <= cnt[i] + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/det_rx_parser.sv
module det_rx_parser
   import det_rx_pkg::*;
#(
   parameter int DATA_W      = 512,
   parameter int USER_W      = 1,
   parameter int MOD_W       = 5,
   parameter int CNT_W       = 32,
   parameter int FRAME_BEATS = 130,
   parameter bit CHECK_MAC   = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DATA_W-1:0]    in_data,
   input  logic [DATA_W/8-1:0]  in_keep,
   input  logic                 in_last,
   input  logic [USER_W-1:0]    in_user,
   input  logic [47:0]          local_mac,
   input  logic [31:0]          local_ip,
   input  logic [15:0]          udp_port,
   input  logic                 clear_counters,
   output logic                 meta_valid,
   input  logic                 meta_ready,
   output logic [63:0]          meta_frame,
   output logic [MOD_W-1:0]     meta_module,
   output logic [6:0]           meta_packet,
   output logic                 meta_trigger,
   output logic                 meta_end,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [DATA_W-1:0]    out_data,
   output logic                 out_last,
   output logic                 out_err,
   output logic [CNT_W-1:0]     pkt_count,
   output logic [CNT_W-1:0]     len_err_count
);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int LO_BYTES   = OFS_PAYLOAD - BEAT_BYTES;
   localparam int HI_BYTES   = BEAT_BYTES - LO_BYTES;
   localparam int IDX_W      = $clog2(FRAME_BEATS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BEATS - 1);
   localparam logic [IDX_W-1:0] FIRST_PAY = IDX_W'(2);

   generate
      if (DATA_W != 512) begin : g_bad_width
         $error("det_rx_parser: header offsets assume 64-byte beats");
      end
      if (MOD_W < 1 || MOD_W > 15) begin : g_bad_mod
         $error("det_rx_parser: MOD_W out of range");
      end
      if (FRAME_BEATS < 3) begin : g_bad_beats
         $error("det_rx_parser: FRAME_BEATS too small");
      end
   endgenerate

   rx_state_e              state;
   logic [IDX_W-1:0]       beat_idx;
   logic [8*HI_BYTES-1:0]  prev_hi;
   logic [63:0]            frame_r;
   logic [5:0]             pkt_r;
   logic [MOD_W:0]         coord_r;
   logic                   trig_r;
   net_hdr_t               hdr;
   logic                   hdr_ok;
   logic                   keep_full;
   logic                   acc;
   logic                   body_ok, body_err, close_pkt;
   logic                   h0_err, h1_err;
   logic [DATA_W-1:0]      merged;
   logic [1:0][CNT_W-1:0]  cnt;

   // network header pulled from the first beat, big-endian fields
   always_comb begin
      hdr = '0;
      for (int i = 0; i < 6; i++)
         hdr.dst_mac[8*(5-i) +: 8] = in_data[8*i +: 8];
      for (int i = 0; i < 4; i++)
         hdr.dst_ip[8*(3-i) +: 8] = in_data[8*(OFS_DSTIP+i) +: 8];
      hdr.etype   = {in_data[8*OFS_ETYPE +: 8],  in_data[8*(OFS_ETYPE+1) +: 8]};
      hdr.ver_ihl = in_data[8*OFS_VERIHL +: 8];
      hdr.ip_len  = {in_data[8*OFS_IPLEN +: 8],  in_data[8*(OFS_IPLEN+1) +: 8]};
      hdr.proto   = in_data[8*OFS_PROTO +: 8];
      hdr.dport   = {in_data[8*OFS_DPORT +: 8],  in_data[8*(OFS_DPORT+1) +: 8]};
      hdr.udp_len = {in_data[8*OFS_UDPLEN +: 8], in_data[8*(OFS_UDPLEN+1) +: 8]};
   end

   det_rx_hdr_check #(.USER_W(USER_W), .CHECK_MAC(CHECK_MAC)) u_hdr (
      .hdr       (hdr),
      .user      (in_user),
      .local_mac (local_mac),
      .local_ip  (local_ip),
      .udp_port  (udp_port),
      .hdr_ok    (hdr_ok)
   );

   det_rx_realign #(.DATA_W(DATA_W), .HI_BYTES(HI_BYTES)) u_align (
      .prev_hi (prev_hi),
      .cur_lo  (in_data[8*LO_BYTES-1:0]),
      .merged  (merged)
   );

   assign keep_full = &in_keep;

   always_comb begin
      unique case (state)
         ST_META: in_ready = 1'b0;
         ST_BODY: in_ready = !out_valid || out_ready;
         default: in_ready = 1'b1;
      endcase
   end

   assign acc       = in_valid && in_ready;
   assign body_ok   = (state == ST_BODY) && acc && in_last && keep_full && (beat_idx == LAST_IDX);
   assign body_err  = (state == ST_BODY) && acc && !body_ok
                   && (in_last || !keep_full || (beat_idx == LAST_IDX));
   assign close_pkt = body_ok || body_err;
   assign h0_err    = (state == ST_HDR0) && acc && hdr_ok && (in_last || !keep_full);
   assign h1_err    = (state == ST_HDR1) && acc && (in_last || !keep_full);

   det_rx_counters #(.N_CNT(2), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear_counters),
      .inc   ({h0_err || h1_err || body_err, body_ok}),
      .cnt   (cnt)
   );
   assign pkt_count     = cnt[0];
   assign len_err_count = cnt[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_HDR0;
         beat_idx   <= '0;
         prev_hi    <= '0;
         frame_r    <= '0;
         pkt_r      <= '0;
         coord_r    <= '0;
         trig_r     <= 1'b0;
         meta_valid <= 1'b0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_last   <= 1'b0;
         out_err    <= 1'b0;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         unique case (state)
            ST_HDR0: if (acc) begin
               frame_r <= in_data[8*OFS_FRAME +: 64];
               pkt_r   <= in_data[8*OFS_PKTNUM +: 6];
               if (!in_last) state <= (hdr_ok && keep_full) ? ST_HDR1 : ST_DROP;
            end
            ST_HDR1: if (acc) begin
               prev_hi <= in_data[DATA_W-1 : 8*LO_BYTES];
               coord_r <= in_data[8*(OFS_COORD-BEAT_BYTES) +: MOD_W+1];
               trig_r  <= in_data[8*(OFS_DEBUG-BEAT_BYTES) + 31];
               if (in_last)         state <= ST_HDR0;
               else if (!keep_full) state <= ST_DROP;
               else begin
                  meta_valid <= 1'b1;
                  beat_idx   <= FIRST_PAY;
                  state      <= ST_META;
               end
            end
            ST_META: if (meta_ready) begin
               meta_valid <= 1'b0;
               state      <= ST_BODY;
            end
            ST_BODY: if (acc) begin
               prev_hi   <= in_data[DATA_W-1 : 8*LO_BYTES];
               out_valid <= 1'b1;
               out_data  <= merged;
               out_last  <= close_pkt;
               out_err   <= body_err;
               beat_idx  <= beat_idx + IDX_W'(1);
               if (close_pkt) state <= in_last ? ST_HDR0 : ST_DROP;
            end
            ST_DROP: if (acc && in_last) state <= ST_HDR0;
            default: state <= ST_HDR0;
         endcase
      end
   end

   assign meta_frame   = frame_r;
   assign meta_module  = coord_r[MOD_W:1];
   assign meta_packet  = {coord_r[0], pkt_r};
   assign meta_trigger = trig_r;
   assign meta_end     = &frame_r;
endmodule

// File: rtl/det_rx_parser_chk.sv
module det_rx_parser_chk #(
   parameter int DATA_W = 512,
   parameter int MOD_W  = 5,
   parameter int CNT_W  = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              clear_counters,
   input logic              meta_valid,
   input logic              meta_ready,
   input logic [63:0]       meta_frame,
   input logic [MOD_W-1:0]  meta_module,
   input logic [6:0]        meta_packet,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              out_err,
   input logic [CNT_W-1:0]  pkt_count,
   input logic [CNT_W-1:0]  len_err_count
);
   AST_META_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      meta_valid && !meta_ready |=> meta_valid && $stable(meta_frame)
         && $stable(meta_module) && $stable(meta_packet));                   // R4
   AST_META_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      meta_valid |-> !in_ready);                                            // R4
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
         && $stable(out_last) && $stable(out_err));                          // R8
   AST_ERR_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> out_last);                                    // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_counters |=> pkt_count == '0 && len_err_count == '0);            // R7
   AST_PKT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_counters |=> (pkt_count == $past(pkt_count))
         || (pkt_count == $past(pkt_count) + CNT_W'(1)));                    // R7
   AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_counters |=> (len_err_count == $past(len_err_count))
         || (len_err_count == $past(len_err_count) + CNT_W'(1)));            // R6
endmodule

bind det_rx_parser det_rx_parser_chk #(.DATA_W(DATA_W), .MOD_W(MOD_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/det_rx_parser_bench.sv
`timescale 1ns/100ps
module det_rx_parser_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         in_valid = 0, in_last = 0, clear_counters = 0;
   logic         meta_ready = 1, out_ready = 1;
   logic [511:0] in_data = '0;
   logic [63:0]  in_keep = '1;
   logic [0:0]   in_user = '0;
   logic         in_ready, meta_valid, meta_trigger, meta_end;
   logic         out_valid, out_last, out_err;
   logic [63:0]  meta_frame;
   logic [4:0]   meta_module;
   logic [6:0]   meta_packet;
   logic [511:0] out_data;
   logic [31:0]  pkt_count, len_err_count;

   localparam logic [47:0] MY_MAC  = 48'h02_1A_2B_3C_4D_5E;
   localparam logic [31:0] MY_IP   = 32'hC0A8_0A07;
   localparam logic [15:0] MY_PORT = 16'hC351;

   det_rx_parser u_det_rx_parser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_keep(in_keep), .in_last(in_last), .in_user(in_user),
      .local_mac(MY_MAC), .local_ip(MY_IP), .udp_port(MY_PORT),
      .clear_counters(clear_counters),
      .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_frame(meta_frame),
      .meta_module(meta_module), .meta_packet(meta_packet),
      .meta_trigger(meta_trigger), .meta_end(meta_end),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_err(out_err),
      .pkt_count(pkt_count), .len_err_count(len_err_count));

   int n_chk = 0, n_bad = 0;
   int exp_pkt = 0, exp_err = 0;
   int meta_pops = 0, meta_pushes = 0;
   bit stall = 0;
   logic [77:0]  exp_meta [$];
   logic [513:0] exp_beat [$];
   int           beat_need [$];
   logic [7:0]   fb [];

   task automatic check(input bit ok, input string req, input logic [599:0] act, input logic [599:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // back-pressure pattern
   always @(negedge clk) begin
      out_ready  = stall ? ($urandom % 3 != 0) : 1'b1;
      meta_ready = stall ? ($urandom % 2 == 0) : 1'b1;
   end

   // handshake monitor
   logic         prev_hold = 0;
   logic [513:0] prev_out = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (prev_hold)
            check(out_valid && {out_err, out_last, out_data} == prev_out, "R8",
                  {out_valid, out_err, out_last, out_data}, {1'b1, prev_out});
         prev_hold = out_valid && !out_ready;
         prev_out  = {out_err, out_last, out_data};
         if (meta_valid && meta_ready) begin
            if (exp_meta.size() == 0) check(0, "R1 unexpected metadata", meta_frame, 0);
            else begin
               logic [77:0] e;
               e = exp_meta.pop_front();
               check({meta_frame, meta_module, meta_packet, meta_trigger, meta_end} == e,
                     "R2 R3 metadata",
                     {meta_frame, meta_module, meta_packet, meta_trigger, meta_end}, e);
            end
            meta_pops++;
         end
         if (out_valid && out_ready) begin
            if (exp_beat.size() == 0) check(0, "R1 unexpected payload", out_data, 0);
            else begin
               logic [513:0] e;
               int need;
               e = exp_beat.pop_front();
               need = beat_need.pop_front();
               check(meta_pops >= need, "R4 metadata before payload", meta_pops, need);
               check({out_err, out_last, out_data} == e, e[513] ? "R6 closing beat" : "R5 payload",
                     {out_err, out_last, out_data}, e);
            end
         end
      end
   end

   task automatic build(input logic [63:0] fnum, input int module_no, input int half,
                        input int pnum, input bit trig, input int nbeats, input int fault);
      int n;
      logic [15:0] coord;
      n = nbeats * 64;
      fb = new[n];
      for (int i = 0; i < n; i++) fb[i] = (i >= 90) ? 8'(i * 13 + pnum * 7 + 5) : 8'hA5;
      for (int i = 0; i < 6; i++) fb[i] = MY_MAC[8*(5-i) +: 8];
      for (int i = 6; i < 12; i++) fb[i] = 8'(i);
      fb[12] = 8'h08; fb[13] = 8'h00; fb[14] = 8'h45; fb[15] = 8'h00;
      fb[16] = 8'h20; fb[17] = 8'h4C; fb[22] = 8'h40; fb[23] = 8'h11;
      for (int i = 0; i < 4; i++) fb[30+i] = MY_IP[8*(3-i) +: 8];
      fb[34] = 8'hDF; fb[35] = 8'hAC;
      fb[36] = MY_PORT[15:8]; fb[37] = MY_PORT[7:0];
      fb[38] = 8'h20; fb[39] = 8'h38;
      for (int i = 0; i < 8; i++) fb[42+i] = fnum[8*i +: 8];
      for (int i = 0; i < 4; i++) fb[50+i] = 8'(i == 0 ? pnum : 0);
      case (fault)
         1: fb[3]  = fb[3] ^ 8'h01;
         2: fb[13] = 8'h06;
         3: fb[14] = 8'h46;
         4: fb[17] = 8'h4D;
         5: fb[23] = 8'h06;
         6: fb[33] = fb[33] ^ 8'h80;
         7: fb[37] = fb[37] ^ 8'h02;
         8: fb[39] = 8'h37;
         default: ;
      endcase
      if (n >= 128) begin
         coord = 16'(2 * module_no + half);
         fb[74] = coord[7:0]; fb[75] = coord[15:8];
         for (int i = 86; i < 89; i++) fb[i] = 8'h00;
         fb[89] = trig ? 8'h80 : 8'h00;
      end
   endtask

   task automatic model(input logic [63:0] fnum, input int module_no, input int half,
                        input int pnum, input bit trig, input int nbeats, input bit hok, input int kbad);
      int endb;
      bit good;
      logic [511:0] d;
      if (!hok) return;
      if (nbeats <= 2 || kbad == 0 || kbad == 1) begin exp_err++; return; end
      exp_meta.push_back({fnum, 5'(module_no), 1'(half), 6'(pnum), trig, fnum == '1});
      meta_pushes++;
      endb = (nbeats - 1 < 129) ? nbeats - 1 : 129;
      if (kbad >= 2 && kbad < endb) endb = kbad;
      good = (nbeats == 130) && (kbad < 0);
      for (int j = 2; j <= endb; j++) begin
         for (int b = 0; b < 64; b++) d[8*b +: 8] = fb[90 + 64*(j-2) + b];
         exp_beat.push_back({(j == endb) && !good, j == endb, d});
         beat_need.push_back(meta_pushes);
      end
      if (good) exp_pkt++; else exp_err++;
   endtask

   task automatic send(input logic [63:0] fnum, input int module_no, input int half,
                       input int pnum, input bit trig, input int nbeats,
                       input int fault, input bit user, input int kbad);
      bit ok;
      int guard;
      build(fnum, module_no, half, pnum, trig, nbeats, fault);
      model(fnum, module_no, half, pnum, trig, nbeats, (fault == 0) && !user, kbad);
      for (int j = 0; j < nbeats; j++) begin
         @(negedge clk);
         for (int b = 0; b < 64; b++) in_data[8*b +: 8] = fb[64*j + b];
         in_keep  = (j == kbad) ? 64'h7FFF_FFFF_FFFF_FFFF : '1;
         in_last  = (j == nbeats - 1);
         in_user  = user;
         in_valid = 1'b1;
         forever begin
            #1 ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; in_user = '0; in_keep = '1;
      guard = 0;
      while ((exp_meta.size() != 0 || exp_beat.size() != 0) && guard < 3000) begin
         @(negedge clk); guard++;
      end
      repeat (6) @(negedge clk);
      #1;
      check(exp_meta.size() == 0 && exp_beat.size() == 0, "R4 R5 all output delivered",
            exp_beat.size(), 0);
      check(pkt_count == 32'(exp_pkt), "R7 packet counter", pkt_count, exp_pkt);
      check(len_err_count == 32'(exp_err), "R6 length error counter", len_err_count, exp_err);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!meta_valid && !out_valid && pkt_count == 0 && len_err_count == 0,
            "R9 reset state", {meta_valid, out_valid, pkt_count, len_err_count}, 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(64'd100, 3, 0, 5, 0, 130, 0, 0, -1);                       // R5 good frame
      stall = 1;
      send(64'h0123_4567_89AB_CDEF, 7, 1, 63, 1, 130, 0, 0, -1);      // R3 second half, trigger
      send('1, 0, 0, 0, 0, 130, 0, 0, -1);                            // R3 end marker
      for (int f = 1; f <= 8; f++) send(64'(200 + f), 1, 0, f, 0, 130, f, 0, -1); // R1 faults
      send(64'd300, 2, 0, 1, 0, 130, 0, 1, -1);                        // R1 user flag
      send(64'd301, 4, 1, 9, 0, 129, 0, 0, -1);                        // R6 short
      send(64'd302, 5, 0, 10, 1, 131, 0, 0, -1);                       // R6 long
      send(64'd303, 6, 0, 11, 0, 1, 0, 0, -1);                         // R6 one beat
      send(64'd304, 6, 0, 12, 0, 2, 0, 0, -1);                         // R6 two beats
      send(64'd305, 9, 1, 13, 0, 130, 0, 0, 50);                       // R6 bad keep
      stall = 0;
      send(64'd306, 31, 1, 40, 1, 130, 0, 0, -1);                      // R2 recovery

      @(negedge clk) clear_counters = 1'b1;
      @(negedge clk) clear_counters = 1'b0;
      #1;
      check(pkt_count == 0 && len_err_count == 0, "R7 clear", {pkt_count, len_err_count}, 0);
      exp_pkt = 0; exp_err = 0;
      send(64'd400, 1, 0, 0, 0, 130, 0, 0, -1);                        // R7 count after clear

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule